// File: doc/BRIEF.md
# Programmable I/O Window Decoder

This block is a slice of a PCI function's configuration space. It holds two programmable I/O base registers, each with its own enable, and turns an incoming I/O address into a hit strobe and a window offset for each of two windows. The power-management window is 128 bytes long. The SMBus host window is 16 bytes long. The register blocks behind each window use the hit to claim the cycle and the offset to pick a register.

Software writes and reads 32-bit configuration dwords with per-byte enables. The device-specific area starts above the standard 64-byte header. Every write that touches a base register normalises the stored value: the address bits inside the window are cleared, bits 31:16 are cleared, and bit 0 is forced to one. The SMBus enable byte keeps only its low nibble. Decoding is combinational on the I/O address and follows the registered configuration. A configuration write therefore changes the decode from the cycle after its clock edge.

Top module: `iowin_decoder`

## Requirements
- R1: After reset, every device-specific byte (0x40 to 0xFF) reads zero except the dwords at 0x48 and 0x90, which read 0x00000001. Both hit outputs are low for every address.
- R2: Any write whose byte enables touch the dword at 0x48 stores (merged value AND 0x0000FF80) OR 1. The merged value is the old dword with the enabled bytes replaced.
- R3: Any write whose byte enables touch the dword at 0x90 stores (merged value AND 0x0000FFF0) OR 1.
- R4: The power-management hit is high only while bit 7 of config byte 0x41 is set and the I/O address lies in [base, base+127], where base is bits 15:0 of the 0x48 dword with bit 0 cleared. The 7-bit offset then equals the address minus base.
- R5: A write that enables config byte 0xD2 stores only the low four bits of that byte. Bit 0 of byte 0xD2 enables the SMBus window, which spans [base, base+15] from the 0x90 dword with bit 0 cleared. Its 4-bit offset equals the address minus base.
- R6: A write changes only the bytes whose enables are set. All other bytes keep their values.
- R7: When an address falls in both windows, only the power-management hit is asserted.
- R8: Dwords in the header area (0x00 to 0x3F) read zero, and writes to them have no effect.
- R9: The read data and the decode reflect a configuration write in the first cycle after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw_addr | input | 6 | Configuration dword index (byte offset / 4) |
| cfg_be | input | 4 | Byte enables for the write, bit n enables byte lane n |
| cfg_wdata | input | 32 | Write data, lane n in bits 8n+7:8n |
| cfg_rdata | output | 32 | Combinational read data for cfg_dw_addr |
| io_addr | input | 16 | I/O address being decoded |
| pm_hit | output | 1 | Address falls in the enabled power-management window |
| pm_offset | output | 7 | Address minus power-management base |
| smb_hit | output | 1 | Address falls in the enabled SMBus window and not in the power-management window |
| smb_offset | output | 4 | Address minus SMBus base |

## Verification
The hardest case to reach from the ports is the one where both windows claim the same address. Software has to place the 16-byte SMBus window inside the 128-byte power-management window, turn both enables on, and then turn the power-management enable off to show that the SMBus hit was suppressed and not absent. The stimulus gets there through normal configuration writes. Other stimulus writes to the base dwords with single-byte enables, including a lane outside the base field. These show that normalisation applies to the merged dword and not to the written bytes alone.

// File: rtl/iowin_pkg.sv
package iowin_pkg;

    // Mask a written base register down to its kept bits and force bit 0 high.
    function automatic logic [31:0] norm_base(input logic [31:0] value,
                                              input logic [31:0] keep);
        return (value & keep) | 32'h0000_0001;
    endfunction

    // Mask of address bits above a window of 2**size_log2 bytes in an io_aw-bit space.
    function automatic logic [31:0] base_keep(input int io_aw, input int size_log2);
        logic [31:0] m;
        m = '0;
        for (int b = 0; b < 32; b++) begin
            if (b >= size_log2 && b < io_aw) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/iowin_cfg_regs.sv
module iowin_cfg_regs #(
    parameter int CFG_AW        = 8,
    parameter int HDR_BYTES     = 64,
    parameter int IO_AW         = 16,
    parameter int PM_BASE_OFS   = 'h48,
    parameter int PM_SIZE_LOG2  = 7,
    parameter int PM_EN_OFS     = 'h41,
    parameter int PM_EN_BIT     = 7,
    parameter int SMB_BASE_OFS  = 'h90,
    parameter int SMB_SIZE_LOG2 = 4,
    parameter int SMB_EN_OFS    = 'hD2,
    parameter int SMB_EN_BIT    = 0,
    parameter logic [7:0] SMB_EN_KEEP = 8'h0F,
    localparam int DW_W = CFG_AW - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [DW_W-1:0]  cfg_dw_addr,
    input  logic [3:0]       cfg_be,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    output logic [IO_AW-1:0] pm_base,
    output logic             pm_en,
    output logic [IO_AW-1:0] smb_base,
    output logic             smb_en
);
    localparam int TOTAL_BYTES = 1 << CFG_AW;
    localparam int DEV_BYTES   = TOTAL_BYTES - HDR_BYTES;
    localparam int HDR_DW      = HDR_BYTES / 4;
    localparam int IW          = $clog2(DEV_BYTES);
    localparam int PM_DW       = PM_BASE_OFS / 4;
    localparam int SMB_DW      = SMB_BASE_OFS / 4;
    localparam int PM_IX       = PM_BASE_OFS - HDR_BYTES;
    localparam int SMB_IX      = SMB_BASE_OFS - HDR_BYTES;
    localparam int PM_EN_IX    = PM_EN_OFS - HDR_BYTES;
    localparam int SMB_EN_IX   = SMB_EN_OFS - HDR_BYTES;
    localparam int SMB_EN_DW   = SMB_EN_OFS / 4;
    localparam int SMB_EN_LANE = SMB_EN_OFS % 4;
    localparam logic [31:0] PM_KEEP  = iowin_pkg::base_keep(IO_AW, PM_SIZE_LOG2);
    localparam logic [31:0] SMB_KEEP = iowin_pkg::base_keep(IO_AW, SMB_SIZE_LOG2);

    typedef struct packed {
        logic [DEV_BYTES-1:0][7:0] mem;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    function automatic cfg_state_t reset_state();
        cfg_state_t r;
        r = '0;
        r.mem[PM_IX]  = 8'h01;
        r.mem[SMB_IX] = 8'h01;
        return r;
    endfunction

    logic            dev_sel_d;
    logic [IW-1:0]   wr_ix_d;
    logic [31:0]     word_d;

    // Next-state computation: byte merge, then normalise the special registers.
    always_comb begin
        st_d      = st_q;
        dev_sel_d = (int'(cfg_dw_addr) >= HDR_DW);
        wr_ix_d   = IW'((int'(cfg_dw_addr) - HDR_DW) * 4);
        word_d    = '0;

        if (cfg_wr && dev_sel_d) begin
            for (int l = 0; l < 4; l++) begin
                if (cfg_be[l]) st_d.mem[wr_ix_d + IW'(l)] = cfg_wdata[8*l +: 8];
            end
        end

        if (cfg_wr && cfg_dw_addr == DW_W'(PM_DW) && (|cfg_be)) begin
            for (int l = 0; l < 4; l++) word_d[8*l +: 8] = st_d.mem[PM_IX + l];
            word_d = iowin_pkg::norm_base(word_d, PM_KEEP);
            for (int l = 0; l < 4; l++) st_d.mem[PM_IX + l] = word_d[8*l +: 8];
        end

        if (cfg_wr && cfg_dw_addr == DW_W'(SMB_DW) && (|cfg_be)) begin
            for (int l = 0; l < 4; l++) word_d[8*l +: 8] = st_d.mem[SMB_IX + l];
            word_d = iowin_pkg::norm_base(word_d, SMB_KEEP);
            for (int l = 0; l < 4; l++) st_d.mem[SMB_IX + l] = word_d[8*l +: 8];
        end

        if (cfg_wr && cfg_dw_addr == DW_W'(SMB_EN_DW) && cfg_be[SMB_EN_LANE]) begin
            st_d.mem[SMB_EN_IX] = st_d.mem[SMB_EN_IX] & SMB_EN_KEEP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= reset_state();
        else        st_q <= st_d;
    end

    // Read port.
    logic [IW-1:0] rd_ix;
    always_comb begin
        rd_ix     = IW'((int'(cfg_dw_addr) - HDR_DW) * 4);
        cfg_rdata = '0;
        if (int'(cfg_dw_addr) >= HDR_DW) begin
            for (int l = 0; l < 4; l++) cfg_rdata[8*l +: 8] = st_q.mem[rd_ix + IW'(l)];
        end
    end

    // Decode-side view of the registers.
    logic [15:0] pm_raw, smb_raw;
    assign pm_raw   = {st_q.mem[PM_IX + 1], st_q.mem[PM_IX]};
    assign smb_raw  = {st_q.mem[SMB_IX + 1], st_q.mem[SMB_IX]};
    assign pm_base  = IO_AW'(pm_raw & PM_KEEP[15:0]);
    assign smb_base = IO_AW'(smb_raw & SMB_KEEP[15:0]);
    assign pm_en    = st_q.mem[PM_EN_IX][PM_EN_BIT];
    assign smb_en   = st_q.mem[SMB_EN_IX][SMB_EN_BIT];

    // R2: a write touching the power-management base leaves it normalised.
    p_pm_norm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_dw_addr == DW_W'(PM_DW) && (|cfg_be))
        |=> (st_q.mem[PM_IX][6:0] == 7'h01 && st_q.mem[PM_IX + 2] == 8'h00
             && st_q.mem[PM_IX + 3] == 8'h00));

    // R3: a write touching the SMBus base leaves it normalised.
    p_smb_norm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_dw_addr == DW_W'(SMB_DW) && (|cfg_be))
        |=> (st_q.mem[SMB_IX][3:0] == 4'h1 && st_q.mem[SMB_IX + 3] == 8'h00));

    // R5: the SMBus enable byte keeps only its low nibble after a write.
    p_en_trunc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_dw_addr == DW_W'(SMB_EN_DW) && cfg_be[SMB_EN_LANE])
        |=> ((st_q.mem[SMB_EN_IX] & ~SMB_EN_KEEP) == 8'h00));

    // R6: the power-management base moves only when its own dword is written.
    p_base_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr && cfg_dw_addr == DW_W'(PM_DW)) |=> $stable(pm_base));

endmodule

// File: rtl/iowin_window.sv
module iowin_window #(
    parameter int IO_AW     = 16,
    parameter int SIZE_LOG2 = 7
) (
    input  logic [IO_AW-1:0]     base,
    input  logic                 en,
    input  logic [IO_AW-1:0]     io_addr,
    output logic                 match,
    output logic [SIZE_LOG2-1:0] offset
);
    logic [IO_AW-1:0] diff;

    // The base is aligned to the window size, so the address is inside the window
    // exactly when the difference has no bits above the window size.
    always_comb begin
        diff   = io_addr - base;
        match  = en && (diff[IO_AW-1:SIZE_LOG2] == '0);
        offset = diff[SIZE_LOG2-1:0];
    end

endmodule

// File: rtl/iowin_decoder.sv
module iowin_decoder #(
    parameter int CFG_AW        = 8,
    parameter int HDR_BYTES     = 64,
    parameter int IO_AW         = 16,
    parameter int PM_SIZE_LOG2  = 7,
    parameter int SMB_SIZE_LOG2 = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr,
    input  logic [CFG_AW-3:0]        cfg_dw_addr,
    input  logic [3:0]               cfg_be,
    input  logic [31:0]              cfg_wdata,
    output logic [31:0]              cfg_rdata,
    input  logic [IO_AW-1:0]         io_addr,
    output logic                     pm_hit,
    output logic [PM_SIZE_LOG2-1:0]  pm_offset,
    output logic                     smb_hit,
    output logic [SMB_SIZE_LOG2-1:0] smb_offset
);
    localparam int HDR_DW = HDR_BYTES / 4;

    logic [IO_AW-1:0] pm_base, smb_base;
    logic             pm_en, smb_en;
    logic             pm_match, smb_match;

    iowin_cfg_regs #(
        .CFG_AW       (CFG_AW),
        .HDR_BYTES    (HDR_BYTES),
        .IO_AW        (IO_AW),
        .PM_SIZE_LOG2 (PM_SIZE_LOG2),
        .SMB_SIZE_LOG2(SMB_SIZE_LOG2)
    ) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_dw_addr(cfg_dw_addr),
        .cfg_be     (cfg_be),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .pm_base    (pm_base),
        .pm_en      (pm_en),
        .smb_base   (smb_base),
        .smb_en     (smb_en)
    );

    iowin_window #(.IO_AW(IO_AW), .SIZE_LOG2(PM_SIZE_LOG2)) i_pm_win (
        .base   (pm_base),
        .en     (pm_en),
        .io_addr(io_addr),
        .match  (pm_match),
        .offset (pm_offset)
    );

    iowin_window #(.IO_AW(IO_AW), .SIZE_LOG2(SMB_SIZE_LOG2)) i_smb_win (
        .base   (smb_base),
        .en     (smb_en),
        .io_addr(io_addr),
        .match  (smb_match),
        .offset (smb_offset)
    );

    // Power management takes precedence on overlap.
    assign pm_hit  = pm_match;
    assign smb_hit = smb_match && !pm_match;

    // R7: never two claims on one address.
    p_one_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(pm_hit && smb_hit));

    // R4: a power-management hit needs its enable.
    p_pm_hit_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pm_hit |-> pm_en);

    // R5: an SMBus hit needs its enable.
    p_smb_hit_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        smb_hit |-> smb_en);

    // R8: the header area reads zero.
    p_hdr_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cfg_dw_addr) < HDR_DW) |-> (cfg_rdata == 32'h0));

endmodule

// File: tb/test_iowin_decoder.sv
`timescale 1ns/1ps
module test_iowin_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_dw_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [15:0] io_addr = '0;
    logic        pm_hit, smb_hit;
    logic [6:0]  pm_offset;
    logic [3:0]  smb_offset;

    always #4 clk = ~clk;

    iowin_decoder i_iowin_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw_addr(cfg_dw_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .io_addr(io_addr), .pm_hit(pm_hit), .pm_offset(pm_offset),
        .smb_hit(smb_hit), .smb_offset(smb_offset)
    );

    typedef struct packed {
        logic [15:0] tag;
        logic        is_rd;
        logic [31:0] exp_rd;
        logic        exp_pm;
        logic [6:0]  exp_pmo;
        logic        exp_smb;
        logic [3:0]  exp_smbo;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    task automatic cfg_write(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] d);
        cfg_wr = 1'b1; cfg_dw_addr = dw; cfg_be = be; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_wr = 1'b0; cfg_be = '0;
    endtask

    task automatic chk_rd(input logic [5:0] dw, input logic [31:0] exp, input logic [15:0] tag);
        item_t it;
        cfg_dw_addr = dw;
        it = '0; it.tag = tag; it.is_rd = 1'b1; it.exp_rd = exp;
        q.push_back(it);
        @(posedge clk); #1;
    endtask

    task automatic chk_io(input logic [15:0] a, input logic pm, input logic [6:0] pmo,
                          input logic smb, input logic [3:0] smbo, input logic [15:0] tag);
        item_t it;
        io_addr = a;
        it = '0; it.tag = tag; it.exp_pm = pm; it.exp_pmo = pmo;
        it.exp_smb = smb; it.exp_smbo = smbo;
        q.push_back(it);
        @(posedge clk); #1;
    endtask

    // Monitor: compares queued expectations away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (it.is_rd) begin
                    if (cfg_rdata !== it.exp_rd) begin
                        errors++;
                        $display("FAIL %s: rdata=%h expected %h", it.tag, cfg_rdata, it.exp_rd);
                    end
                end else begin
                    if (pm_hit !== it.exp_pm || smb_hit !== it.exp_smb
                        || (it.exp_pm && pm_offset !== it.exp_pmo)
                        || (it.exp_smb && smb_offset !== it.exp_smbo)) begin
                        errors++;
                        $display("FAIL %s: pm=%b/%h smb=%b/%h expected pm=%b/%h smb=%b/%h",
                                 it.tag, pm_hit, pm_offset, smb_hit, smb_offset,
                                 it.exp_pm, it.exp_pmo, it.exp_smb, it.exp_smbo);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values
        chk_rd(6'h12, 32'h0000_0001, "R1");
        chk_rd(6'h24, 32'h0000_0001, "R1");
        chk_rd(6'h10, 32'h0000_0000, "R1");
        chk_rd(6'h34, 32'h0000_0000, "R1");
        chk_io(16'h0000, 0, 0, 0, 0, "R1");

        // R8: header area ignores writes
        cfg_write(6'h01, 4'hF, 32'hFFFF_FFFF);
        chk_rd(6'h01, 32'h0, "R8");

        // R2: full and partial writes to the power-management base
        cfg_write(6'h12, 4'hF, 32'hDEAD_BEEF);
        chk_rd(6'h12, 32'h0000_BE81, "R2");
        cfg_write(6'h12, 4'b0010, 32'h0000_4000);
        chk_rd(6'h12, 32'h0000_4081, "R2");
        cfg_write(6'h12, 4'b0001, 32'h0000_00FF);
        chk_rd(6'h12, 32'h0000_4081, "R2");
        cfg_write(6'h12, 4'b1000, 32'hFF00_0000);
        chk_rd(6'h12, 32'h0000_4081, "R2");

        // R9: decode changes right after the enabling write
        chk_io(16'h4080, 0, 0, 0, 0, "R9");
        cfg_write(6'h10, 4'b0010, 32'h0000_8000);
        chk_io(16'h4080, 1, 7'h00, 0, 0, "R9");
        chk_rd(6'h10, 32'h0000_8000, "R6");

        // R4: window edges
        chk_io(16'h40FF, 1, 7'h7F, 0, 0, "R4");
        chk_io(16'h4100, 0, 0, 0, 0, "R4");
        chk_io(16'h407F, 0, 0, 0, 0, "R4");
        chk_io(16'h40A5, 1, 7'h25, 0, 0, "R4");

        // R3: SMBus base normalisation
        cfg_write(6'h24, 4'hF, 32'h1234_5678);
        chk_rd(6'h24, 32'h0000_5671, "R3");
        chk_io(16'h5670, 0, 0, 0, 0, "R5");

        // R5: enable byte truncation and SMBus decode
        cfg_write(6'h34, 4'b0100, 32'h00FF_0000);
        chk_rd(6'h34, 32'h000F_0000, "R5");
        chk_io(16'h5675, 0, 0, 1, 4'h5, "R5");
        chk_io(16'h567F, 0, 0, 1, 4'hF, "R5");
        chk_io(16'h5680, 0, 0, 0, 0, "R5");
        chk_io(16'h566F, 0, 0, 0, 0, "R5");

        // R6: lanes without enable keep their value
        cfg_write(6'h34, 4'b1011, 32'hFFFF_FFFF);
        chk_rd(6'h34, 32'hFF0F_FFFF, "R6");
        chk_rd(6'h12, 32'h0000_4081, "R6");

        // R7: overlap, power management wins
        cfg_write(6'h24, 4'hF, 32'h0000_4090);
        chk_rd(6'h24, 32'h0000_4091, "R3");
        chk_io(16'h4095, 1, 7'h15, 0, 0, "R7");
        cfg_write(6'h10, 4'b0010, 32'h0000_0000);
        chk_io(16'h4095, 0, 0, 1, 4'h5, "R7");

        // R5: clearing bit 0 disables the SMBus window
        cfg_write(6'h34, 4'b0100, 32'h000E_0000);
        chk_io(16'h4095, 0, 0, 0, 0, "R5");

        // R1: reset again restores defaults
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        chk_rd(6'h24, 32'h0000_0001, "R1");
        chk_rd(6'h34, 32'h0000_0000, "R1");

        @(posedge clk); #1;
        @(posedge clk); #1;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule